// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block is the last stage of the read path in a synchronous burst SRAM model. Each rising clock edge captures a command: read, deselect, or neither. The array is outside the block. It returns the word for a captured read during the cycle that follows that capture edge. The block decides when that word reaches the data bus, how long the bus stays driven, and when the bus is released.

Two static mode inputs set the timing. The first picks flow-through output, where the array word goes straight to the bus, or pipelined output, where a rising-edge output register adds one cycle. The second picks how far a deselect is pipelined. With single-cycle release, the bus lets go one stage earlier than read data would appear. With dual-cycle release, the bus lets go at the same depth as read data.

An asynchronous active-low output enable and an asynchronous active-high sleep input can both force the bus off at any time. While sleep is high the block ignores commands and keeps its stored word. The tri-state bus is modelled as a data vector plus a drive-enable. The data vector reads zero whenever it is not driven. A valid flag marks each cycle in which a new read word is on the bus.

Top module: `sram_rd_out`

## Requirements
- R1: After reset `dq_oe` and `out_valid` are 0, `dq_out` is 0, and the latched modes are pipelined output with single-cycle release.
- R2: In flow-through mode (latched `mode_pipe` = 0), a read captured at edge k puts the array word on `dq_out` with `dq_oe` = 1 and `out_valid` = 1 in the cycle right after edge k.
- R3: In pipelined mode (latched `mode_pipe` = 1), a read captured at edge k leaves `out_valid` low after edge k. After edge k+1 it shows the word with `dq_oe` = 1 and `out_valid` = 1.
- R4: Once a word has been shown, edges that capture no command keep the bus driven with that same word, with `out_valid` = 0.
- R5: In pipelined mode with single-cycle release (latched `mode_dcd` = 0), a deselect captured at edge k drops `dq_oe` right after edge k.
- R6: In pipelined mode with dual-cycle release (latched `mode_dcd` = 1), a deselect captured at edge k keeps the bus driven after edge k. It drops `dq_oe` after edge k+1.
- R7: In flow-through mode, a deselect captured at edge k drops `dq_oe` right after edge k in both release modes.
- R8: While `oe_n` is 1, `dq_oe`, `out_valid` and `dq_out` are 0 at once, with no clock edge needed. Lowering `oe_n` restores the bus.
- R9: While `sleep` is 1 the bus is off and requests are not captured. After `sleep` falls, the previously shown word is driven again unchanged.
- R10: The mode inputs are latched only at an edge where the block is idle: no bus drive pending, no read captured, and no word in the output stage. Changes at other times have no effect until the block is idle.
- R11: When `rd_req` and `dsel_req` are both 1 at an edge, the read is captured and the deselect is dropped.
- R12: In pipelined mode with single-cycle release, a read at edge k followed by a deselect at edge k+1 never drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_req | input | 1 | Read command, captured at the rising edge |
| dsel_req | input | 1 | Deselect command, captured at the rising edge |
| rd_data | input | DATA_W | Array word, valid in the cycle after a captured read |
| mode_pipe | input | 1 | 1 = pipelined output, 0 = flow-through |
| mode_dcd | input | 1 | 1 = dual-cycle release, 0 = single-cycle release |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous low-power request, active high |
| dq_out | output | DATA_W | Bus data, zero when not driven |
| dq_oe | output | 1 | Bus drive enable |
| out_valid | output | 1 | A new read word is on the bus this cycle |

## Verification
Single reads are run in all four mode combinations, and the first valid cycle is checked. This separates flow-through latency from pipelined latency. A read, an idle edge and then a deselect are run in each mode. This separates single-cycle release from dual-cycle release, and checks that an idle edge holds the bus. Further patterns cover a read followed at once by a deselect, read and deselect requested together, and mode inputs toggled while the bus is driven. These show that a release can cut a pipelined read short, that the read wins when both are requested, and that a mode change waits for idle. Toggles of output enable and sleep in the middle of a cycle show that both act at once and that the stored word survives sleep.

// File: rtl/sram_rd_out_pkg.sv
package sram_rd_out_pkg;

  // Latched timing configuration of the output stage.
  typedef struct packed {
    logic pipe;  // 1: output register in path
    logic dcd;   // 1: release at read depth
  } rdo_mode_t;

  localparam rdo_mode_t RDO_MODE_RST = '{pipe: 1'b1, dcd: 1'b0};

endpackage

// File: rtl/rdo_cmd_reg.sv
module rdo_cmd_reg
  import sram_rd_out_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep,
  input  logic      rd_req,
  input  logic      dsel_req,
  input  logic      mode_pipe,
  input  logic      mode_dcd,
  input  logic      idle,
  output logic      rd_q,
  output logic      ds_q,
  output rdo_mode_t mode_q
);

  logic      rd_d;
  logic      ds_d;
  logic      mode_en;
  rdo_mode_t mode_d;

  // Next state: read wins over deselect, sleep blocks capture.
  always_comb begin
    rd_d    = rd_req & ~sleep;
    ds_d    = dsel_req & ~rd_req & ~sleep;
    mode_en = idle;
    mode_d  = mode_q;
    if (mode_en) begin
      mode_d.pipe = mode_pipe;
      mode_d.dcd  = mode_dcd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      ds_q   <= 1'b0;
      mode_q <= RDO_MODE_RST;
    end else begin
      rd_q   <= rd_d;
      ds_q   <= ds_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/rdo_data_reg.sv
module rdo_data_reg #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_q,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout_q,
  output logic              v_q
);

  logic              load_en;
  logic [DATA_W-1:0] dout_d;

  always_comb begin
    load_en = rd_q;
    dout_d  = load_en ? rd_data : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      v_q    <= 1'b0;
    end else begin
      dout_q <= dout_d;
      v_q    <= rd_q;
    end
  end

endmodule

// File: rtl/rdo_drive_ctl.sv
module rdo_drive_ctl
  import sram_rd_out_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_q,
  input  logic      ds_q,
  input  rdo_mode_t mode_q,
  output logic      on_q,
  output logic      bus_on
);

  logic on_d;

  // The drive state sets one edge after a captured read and clears one edge
  // after a captured deselect. The release timing then picks how early the
  // captured deselect masks it.
  always_comb begin
    on_d = on_q;
    if (rd_q)      on_d = 1'b1;
    else if (ds_q) on_d = 1'b0;

    if (mode_q.pipe) begin
      bus_on = mode_q.dcd ? on_q : (on_q & ~ds_q);
    end else begin
      bus_on = rd_q | (on_q & ~ds_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_q <= 1'b0;
    else        on_q <= on_d;
  end

endmodule

// File: rtl/sram_rd_out.sv
module sram_rd_out
  import sram_rd_out_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              dsel_req,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              mode_pipe,
  input  logic              mode_dcd,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              out_valid
);

  localparam int LANES = DATA_W / LANE_W;

  logic              rd_q;
  logic              ds_q;
  rdo_mode_t         mode_q;
  logic [DATA_W-1:0] dout_q;
  logic              v_q;
  logic              on_q;
  logic              bus_on;
  logic              idle;
  logic              gate;
  logic              fresh;
  logic [DATA_W-1:0] word;
  logic              mode_pipe_q;
  logic              mode_dcd_q;

  assign idle        = ~on_q & ~rd_q & ~v_q;
  assign mode_pipe_q = mode_q.pipe;
  assign mode_dcd_q  = mode_q.dcd;

  rdo_cmd_reg u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .rd_req    (rd_req),
    .dsel_req  (dsel_req),
    .mode_pipe (mode_pipe),
    .mode_dcd  (mode_dcd),
    .idle      (idle),
    .rd_q      (rd_q),
    .ds_q      (ds_q),
    .mode_q    (mode_q)
  );

  rdo_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_q    (rd_q),
    .rd_data (rd_data),
    .dout_q  (dout_q),
    .v_q     (v_q)
  );

  rdo_drive_ctl u_drv (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_q   (rd_q),
    .ds_q   (ds_q),
    .mode_q (mode_q),
    .on_q   (on_q),
    .bus_on (bus_on)
  );

  // Output selection and asynchronous gating.
  always_comb begin
    gate = ~oe_n & ~sleep;
    if (mode_q.pipe) begin
      word  = dout_q;
      fresh = v_q;
    end else begin
      word  = rd_q ? rd_data : dout_q;
      fresh = rd_q;
    end
    dq_oe     = bus_on & gate;
    out_valid = fresh & dq_oe;
  end

  // Per-lane bus drivers: an undriven lane reads as zero.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq_out[g*LANE_W +: LANE_W] = dq_oe ? word[g*LANE_W +: LANE_W] : '0;
  end
  if (LANES * LANE_W < DATA_W) begin : g_tail
    assign dq_out[DATA_W-1:LANES*LANE_W] = dq_oe ? word[DATA_W-1:LANES*LANE_W] : '0;
  end

endmodule

// File: rtl/sram_rd_out_chk.sv
module sram_rd_out_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              dsel_req,
  input logic              oe_n,
  input logic              sleep,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              out_valid,
  input logic              idle,
  input logic              mode_pipe_q,
  input logic              mode_dcd_q
);

  assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dq_oe && !out_valid));

  assert_undriven_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

  assert_sleep_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);

  assert_valid_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> dq_oe);

  assert_early_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dsel_req && !rd_req && !sleep && (!mode_dcd_q || !mode_pipe_q)) |=> !dq_oe);

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(mode_pipe_q) && $stable(mode_dcd_q)));

endmodule

bind sram_rd_out sram_rd_out_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req      (rd_req),
  .dsel_req    (dsel_req),
  .oe_n        (oe_n),
  .sleep       (sleep),
  .dq_out      (dq_out),
  .dq_oe       (dq_oe),
  .out_valid   (out_valid),
  .idle        (idle),
  .mode_pipe_q (mode_pipe_q),
  .mode_dcd_q  (mode_dcd_q)
);

// File: tb/sim_sram_rd_out.sv
module sim_sram_rd_out;

  localparam int W = 36;

  logic         clk;
  logic         rst_n;
  logic         rd_req;
  logic         dsel_req;
  logic [W-1:0] rd_data;
  logic         mode_pipe;
  logic         mode_dcd;
  logic         oe_n;
  logic         sleep;
  logic [W-1:0] dq_out;
  logic         dq_oe;
  logic         out_valid;

  int n_run;
  int n_fail;
  bit done;

  sram_rd_out #(.DATA_W(W), .LANE_W(9)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .dsel_req  (dsel_req),
    .rd_data   (rd_data),
    .mode_pipe (mode_pipe),
    .mode_dcd  (mode_dcd),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .out_valid (out_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bus(input string req, input logic [W-1:0] d, input logic oe, input logic v);
    chk({req, " data"}, dq_out, d);
    chk({req, " oe"}, {{(W-1){1'b0}}, dq_oe}, {{(W-1){1'b0}}, oe});
    chk({req, " valid"}, {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, v});
  endtask

  // One clock: requests set at the falling edge, the array word arrives just
  // after the rising edge, outputs are sampled 2 ns after the rising edge.
  task automatic cyc(input logic rd, input logic ds, input logic [W-1:0] d);
    @(negedge clk);
    rd_req   = rd;
    dsel_req = ds;
    @(posedge clk);
    #1 rd_data = d;
    rd_req   = 1'b0;
    dsel_req = 1'b0;
    #1;
  endtask

  task automatic set_mode(input logic p, input logic d);
    mode_pipe = p;
    mode_dcd  = d;
    cyc(1'b0, 1'b0, '0);
    cyc(1'b0, 1'b0, '0);
    cyc(1'b0, 1'b0, '0);
  endtask

  task automatic t_reset;
    chk_bus("R1 reset", '0, 1'b0, 1'b0);
  endtask

  task automatic t_pipe_scd;
    cyc(1'b1, 1'b0, 36'h1_1111_1111);
    chk_bus("R3 pipe not yet", '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 36'h2_2222_2222);
    chk_bus("R3 pipe word", 36'h1_1111_1111, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 36'h3_3333_3333);
    chk_bus("R4 pipe hold", 36'h1_1111_1111, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, '0);
    chk_bus("R5 scd release", '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, '0);
    chk_bus("R5 stays off", '0, 1'b0, 1'b0);
  endtask

  task automatic t_pipe_dcd;
    set_mode(1'b1, 1'b1);
    cyc(1'b1, 1'b0, 36'hA_0000_00A2);
    cyc(1'b0, 1'b0, '0);
    chk_bus("R3 dcd word", 36'hA_0000_00A2, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, '0);
    chk_bus("R6 dcd still driven", 36'hA_0000_00A2, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, '0);
    chk_bus("R6 dcd released", '0, 1'b0, 1'b0);
  endtask

  task automatic t_flow;
    set_mode(1'b0, 1'b0);
    cyc(1'b1, 1'b0, 36'hF_0000_00F1);
    chk_bus("R2 ft word", 36'hF_0000_00F1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 36'h5_5555_5555);
    chk_bus("R4 ft hold", 36'hF_0000_00F1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, '0);
    chk_bus("R7 ft scd release", '0, 1'b0, 1'b0);
    set_mode(1'b0, 1'b1);
    cyc(1'b1, 1'b0, 36'hF_0000_00F2);
    chk_bus("R2 ft dcd word", 36'hF_0000_00F2, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, '0);
    chk_bus("R7 ft dcd release", '0, 1'b0, 1'b0);
  endtask

  task automatic t_priority;
    cyc(1'b1, 1'b1, 36'h0_0000_0ABC);
    chk_bus("R11 read wins", 36'h0_0000_0ABC, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 36'h0_0000_0DEF);
    chk_bus("R11 deselect dropped", 36'h0_0000_0ABC, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, '0);
    cyc(1'b0, 1'b0, '0);
  endtask

  task automatic t_oe;
    cyc(1'b1, 1'b0, 36'h6_0000_0006);
    oe_n = 1'b1;
    #1;
    chk_bus("R8 oe forced off", '0, 1'b0, 1'b0);
    oe_n = 1'b0;
    #1;
    chk_bus("R8 oe restored", 36'h6_0000_0006, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, '0);
    cyc(1'b0, 1'b0, '0);
  endtask

  task automatic t_sleep;
    set_mode(1'b1, 1'b0);
    cyc(1'b1, 1'b0, 36'h7_0000_0007);
    cyc(1'b0, 1'b0, '0);
    chk_bus("R9 before sleep", 36'h7_0000_0007, 1'b1, 1'b1);
    @(negedge clk);
    sleep = 1'b1;
    #1;
    chk_bus("R9 asleep off", '0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 36'h9_9999_9999);
    cyc(1'b1, 1'b0, 36'h8_8888_8888);
    chk_bus("R9 asleep ignores read", '0, 1'b0, 1'b0);
    @(negedge clk);
    sleep = 1'b0;
    cyc(1'b0, 1'b0, '0);
    chk_bus("R9 word kept", 36'h7_0000_0007, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, '0);
    cyc(1'b0, 1'b0, '0);
  endtask

  task automatic t_back_to_back;
    cyc(1'b1, 1'b0, 36'h0_0000_0012);
    cyc(1'b0, 1'b1, 36'h0_0000_0034);
    chk_bus("R12 never driven", '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, '0);
    chk_bus("R12 still off", '0, 1'b0, 1'b0);
  endtask

  task automatic t_mode_lock;
    cyc(1'b1, 1'b0, 36'h0_0000_0AA1);
    cyc(1'b0, 1'b0, '0);
    chk_bus("R10 pipe word", 36'h0_0000_0AA1, 1'b1, 1'b1);
    mode_pipe = 1'b0;
    cyc(1'b1, 1'b0, 36'h0_0000_0AA2);
    chk_bus("R10 change ignored", 36'h0_0000_0AA1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, '0);
    chk_bus("R10 still pipelined", 36'h0_0000_0AA2, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, '0);
    cyc(1'b0, 1'b0, '0);
    cyc(1'b0, 1'b0, '0);
    cyc(1'b1, 1'b0, 36'h0_0000_0AA3);
    chk_bus("R10 latched when idle", 36'h0_0000_0AA3, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, '0);
    cyc(1'b0, 1'b0, '0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run     = 0;
    n_fail    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    rd_req    = 1'b0;
    dsel_req  = 1'b0;
    rd_data   = '0;
    mode_pipe = 1'b1;
    mode_dcd  = 1'b0;
    oe_n      = 1'b0;
    sleep     = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, '0);
    t_reset();
    t_pipe_scd();
    t_pipe_dcd();
    t_flow();
    t_priority();
    t_oe();
    t_sleep();
    t_back_to_back();
    t_mode_lock();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule